// File: doc/BRIEF.md
# Flow-Controlled Box Address Generator

This block carries out one two-dimensional (box) transfer command. It turns a source base address, a destination base address and three packed geometry words into a stream of read/write word-address pairs, one pair per 32-bit beat. The addresses are laid out as rows of a given length, repeated a given number of times. Each side has its own stride, and that stride is added to a row's start address to give the start of the next row. Moving the data and handling the bus handshakes is left to the logic around it.

A command may name one of several peripheral request lines. When it does, a rising edge on that line releases a row. Each line has a small control register that sets how many bytes one request releases, through an encoded block size. If a row is longer than one block, it stops at each block boundary and waits for another request. Line 0 means no flow control, and rows then run back to back. The control register can also clear a line and switch it to an alternate request input.

Top module: `box_addr_gen`

## Requirements
- R1: After synchronous reset, `beat_valid` and `done` are low, and every line has block code 0, primary input selected and no request pending.
- R2: Each geometry word holds a source half in bits 31:16 and a destination half in bits 15:0. A row has ceil(L/4) beats, where L is the smaller byte length of the two halves of `row_len`. Within a row, `rd_addr` starts at the source row start and `wr_addr` at the destination row start, and each rises by 4 per beat.
- R3: The number of rows is the smaller of the two halves of `row_cnt`. Each new row starts at the previous row start plus the matching half of `row_off` (source bits 31:16, destination bits 15:0).
- R4: A stride of zero makes every row start at the same address as the first.
- R5: If either length half or either count half is zero, the command emits no beats and still pulses `done`.
- R6: `done` is a one-cycle pulse in the cycle right after the last beat, and it never coincides with a beat.
- R7: With `fc_line` = 0, all beats of a command come out on consecutive cycles.
- R8: With a nonzero `fc_line`, the first beat of each row waits for a rising request on that line. Inside a row, output pauses after every block until the next rising request. Block code (control bits 2:0) 0..5 gives 16, 32, 64, 128, 192 or 256 bytes (4, 8, 16, 32, 48 or 64 beats), and codes 6 and 7 give 256 bytes. A request on any other line has no effect.
- R9: A rising request that comes while the generator is not waiting is held (one deep) and used by the next wait on that line.
- R10: Control bit 18 set selects the alternate input `req_b` for that line. Clear selects `req_a`.
- R11: Writing a line's control word with bit 17 set returns that line to code 0 with `req_a` selected, and drops its pending request.
- R12: A `start` pulse while a command is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle command start, accepted when idle |
| src_addr | input | AW | Source base byte address |
| dst_addr | input | AW | Destination base byte address |
| row_len | input | 32 | Row byte lengths, source 31:16, destination 15:0 |
| row_cnt | input | 32 | Row counts, source 31:16, destination 15:0 |
| row_off | input | 32 | Row strides, source 31:16, destination 15:0 |
| fc_line | input | LW | Request line for the command, 0 = none |
| req_a | input | LINES | Primary request inputs, one per line |
| req_b | input | LINES | Alternate request inputs, one per line |
| ctl_we | input | 1 | Line control write strobe |
| ctl_line | input | LW | Line addressed by the control write |
| ctl_wdata | input | 19 | Control word: 2:0 block code, 17 clear, 18 alternate input |
| beat_valid | output | 1 | An address pair is present |
| rd_addr | output | AW | Read address of the beat |
| wr_addr | output | AW | Write address of the beat |
| done | output | 1 | Command complete pulse |

## Verification
A corrupted beat or row counter shows at the ports straight away. The number of beats between `done` pulses comes out wrong, or the address jumps by the stride one beat early or late, so the first faulty row gives it away. A wrong row-start register makes the next row begin at the wrong address, on the first beat of that row. Faults in the block counter or in a line's pending flag show up as beats that come out with no request, or as a stall that lasts until the bench watchdog fires. Each directed test therefore counts the beats seen between request pulses, as well as comparing every address.

// File: rtl/box_pkg.sv
package box_pkg;

  localparam int HALF_W  = 16;
  localparam int CODE_W  = 3;
  localparam int BLK_W   = 7;
  localparam int CLR_BIT = 17;
  localparam int ALT_BIT = 18;
  localparam int CTL_W   = ALT_BIT + 1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_RUN,
    ST_FIN
  } seq_state_t;

  // Beats released per request for a block code (4 bytes per beat).
  function automatic logic [BLK_W-1:0] blk_beats(input logic [CODE_W-1:0] code);
    case (code)
      3'd0:    blk_beats = 7'd4;
      3'd1:    blk_beats = 7'd8;
      3'd2:    blk_beats = 7'd16;
      3'd3:    blk_beats = 7'd32;
      3'd4:    blk_beats = 7'd48;
      default: blk_beats = 7'd64;
    endcase
  endfunction

endpackage

// File: rtl/box_fc_lines.sv
module box_fc_lines
  import box_pkg::*;
#(
  parameter int LINES = 16,
  parameter int LW    = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINES-1:0]  req_a,
  input  logic [LINES-1:0]  req_b,
  input  logic              ctl_we,
  input  logic [LW-1:0]     ctl_line,
  input  logic [CODE_W-1:0] ctl_code,
  input  logic              ctl_clr,
  input  logic              ctl_alt,
  input  logic [LW-1:0]     sel,
  input  logic              consume,
  output logic              sel_pend,
  output logic [CODE_W-1:0] sel_code,
  output logic [LINES-1:0]  pend_vec
);

  logic [CODE_W-1:0] code_vec [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [CODE_W-1:0] code_q;
    logic              alt_q;
    logic              prev_q;
    logic              pend_q;
    logic              cur;
    logic              hit;

    assign cur = alt_q ? req_b[i] : req_a[i];
    assign hit = ctl_we && (ctl_line == LW'(i));

    always_ff @(posedge clk) begin
      if (rst || (hit && ctl_clr)) begin
        code_q <= '0;
        alt_q  <= 1'b0;
        prev_q <= 1'b1;
        pend_q <= 1'b0;
      end else begin
        if (hit) begin
          code_q <= ctl_code;
          alt_q  <= ctl_alt;
        end
        prev_q <= cur;
        if (cur && !prev_q)
          pend_q <= 1'b1;
        else if (consume && (sel == LW'(i)))
          pend_q <= 1'b0;
      end
    end

    assign code_vec[i] = code_q;
    assign pend_vec[i] = pend_q;
  end

  assign sel_pend = pend_vec[sel];
  assign sel_code = code_vec[sel];

endmodule

// File: rtl/box_row_seq.sv
module box_row_seq
  import box_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [AW-1:0]     src_addr,
  input  logic [AW-1:0]     dst_addr,
  input  logic [31:0]       row_len,
  input  logic [31:0]       row_cnt,
  input  logic [31:0]       row_off,
  input  logic [LW-1:0]     fc_line,
  input  logic              sel_pend,
  input  logic [CODE_W-1:0] sel_code,
  output logic [LW-1:0]     sel,
  output logic              consume,
  output logic              beat_valid,
  output logic [AW-1:0]     rd_addr,
  output logic [AW-1:0]     wr_addr,
  output logic              done
);

  localparam int BW = HALF_W - 1;

  seq_state_t        state;
  logic [BW-1:0]     beats_q, beat_i;
  logic [HALF_W-1:0] rows_q, row_i;
  logic [HALF_W-1:0] src_str, dst_str;
  logic [BLK_W-1:0]  blk_i;
  logic [AW-1:0]     row_rd, row_wr, cur_rd, cur_wr;
  logic [LW-1:0]     line_q;

  logic [HALF_W-1:0] min_len, min_cnt;
  logic [HALF_W:0]   len_round;
  logic [BW-1:0]     beats_new;
  logic [AW-1:0]     nxt_rd, nxt_wr;
  logic              fc_on, last_beat, last_row, blk_end;

  assign min_len   = (row_len[31:16] < row_len[15:0]) ? row_len[31:16] : row_len[15:0];
  assign min_cnt   = (row_cnt[31:16] < row_cnt[15:0]) ? row_cnt[31:16] : row_cnt[15:0];
  assign len_round = {1'b0, min_len} + (HALF_W+1)'(3);
  assign beats_new = len_round[HALF_W:2];

  assign nxt_rd    = row_rd + {{(AW-HALF_W){1'b0}}, src_str};
  assign nxt_wr    = row_wr + {{(AW-HALF_W){1'b0}}, dst_str};
  assign fc_on     = (line_q != '0);
  assign last_beat = (beat_i == beats_q - 1'b1);
  assign last_row  = (row_i == rows_q - 1'b1);
  assign blk_end   = (blk_i == blk_beats(sel_code) - 7'd1);

  assign sel     = line_q;
  assign consume = (state == ST_WAIT) && sel_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      beats_q    <= '0;
      beat_i     <= '0;
      rows_q     <= '0;
      row_i      <= '0;
      src_str    <= '0;
      dst_str    <= '0;
      blk_i      <= '0;
      row_rd     <= '0;
      row_wr     <= '0;
      cur_rd     <= '0;
      cur_wr     <= '0;
      line_q     <= '0;
      beat_valid <= 1'b0;
      rd_addr    <= '0;
      wr_addr    <= '0;
      done       <= 1'b0;
    end else begin
      beat_valid <= 1'b0;
      done       <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            beats_q <= beats_new;
            rows_q  <= min_cnt;
            src_str <= row_off[31:16];
            dst_str <= row_off[15:0];
            row_rd  <= src_addr;
            row_wr  <= dst_addr;
            cur_rd  <= src_addr;
            cur_wr  <= dst_addr;
            line_q  <= fc_line;
            beat_i  <= '0;
            row_i   <= '0;
            blk_i   <= '0;
            if (beats_new == '0 || min_cnt == '0)
              state <= ST_FIN;
            else if (fc_line != '0)
              state <= ST_WAIT;
            else
              state <= ST_RUN;
          end
        end
        ST_WAIT: begin
          if (sel_pend) begin
            blk_i <= '0;
            state <= ST_RUN;
          end
        end
        ST_RUN: begin
          beat_valid <= 1'b1;
          rd_addr    <= cur_rd;
          wr_addr    <= cur_wr;
          if (last_beat) begin
            if (last_row) begin
              state <= ST_FIN;
            end else begin
              row_i  <= row_i + 1'b1;
              beat_i <= '0;
              blk_i  <= '0;
              row_rd <= nxt_rd;
              row_wr <= nxt_wr;
              cur_rd <= nxt_rd;
              cur_wr <= nxt_wr;
              state  <= fc_on ? ST_WAIT : ST_RUN;
            end
          end else begin
            beat_i <= beat_i + 1'b1;
            cur_rd <= cur_rd + AW'(4);
            cur_wr <= cur_wr + AW'(4);
            if (fc_on && blk_end) begin
              blk_i <= '0;
              state <= ST_WAIT;
            end else begin
              blk_i <= blk_i + 1'b1;
            end
          end
        end
        default: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/box_addr_gen.sv
module box_addr_gen
  import box_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LINES = 16,
  parameter int LW    = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [AW-1:0]    src_addr,
  input  logic [AW-1:0]    dst_addr,
  input  logic [31:0]      row_len,
  input  logic [31:0]      row_cnt,
  input  logic [31:0]      row_off,
  input  logic [LW-1:0]    fc_line,
  input  logic [LINES-1:0] req_a,
  input  logic [LINES-1:0] req_b,
  input  logic             ctl_we,
  input  logic [LW-1:0]    ctl_line,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic             beat_valid,
  output logic [AW-1:0]    rd_addr,
  output logic [AW-1:0]    wr_addr,
  output logic             done
);

  logic [LW-1:0]     sel;
  logic              consume;
  logic              sel_pend;
  logic [CODE_W-1:0] sel_code;
  logic [LINES-1:0]  pend_vec;

  box_fc_lines #(.LINES(LINES), .LW(LW)) u_lines (
    .clk      (clk),
    .rst      (rst),
    .req_a    (req_a),
    .req_b    (req_b),
    .ctl_we   (ctl_we),
    .ctl_line (ctl_line),
    .ctl_code (ctl_wdata[CODE_W-1:0]),
    .ctl_clr  (ctl_wdata[CLR_BIT]),
    .ctl_alt  (ctl_wdata[ALT_BIT]),
    .sel      (sel),
    .consume  (consume),
    .sel_pend (sel_pend),
    .sel_code (sel_code),
    .pend_vec (pend_vec)
  );

  box_row_seq #(.AW(AW), .LW(LW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .src_addr   (src_addr),
    .dst_addr   (dst_addr),
    .row_len    (row_len),
    .row_cnt    (row_cnt),
    .row_off    (row_off),
    .fc_line    (fc_line),
    .sel_pend   (sel_pend),
    .sel_code   (sel_code),
    .sel        (sel),
    .consume    (consume),
    .beat_valid (beat_valid),
    .rd_addr    (rd_addr),
    .wr_addr    (wr_addr),
    .done       (done)
  );

endmodule

// File: rtl/box_addr_gen_chk.sv
module box_addr_gen_chk #(
  parameter int LINES = 16,
  parameter int LW    = 4,
  parameter int CTL_W = 19
) (
  input logic             clk,
  input logic             rst,
  input logic             beat_valid,
  input logic             done,
  input logic             ctl_we,
  input logic [LW-1:0]    ctl_line,
  input logic [CTL_W-1:0] ctl_wdata,
  input logic [LINES-1:0] pend_vec
);

  // R6
  done_no_beat_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !beat_valid);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6
  done_then_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !beat_valid);

  // R11
  line_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && ctl_wdata[17]) |=> !pend_vec[$past(ctl_line)]);

endmodule

bind box_addr_gen box_addr_gen_chk #(.LINES(LINES), .LW(LW), .CTL_W(box_pkg::CTL_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .beat_valid (beat_valid),
  .done       (done),
  .ctl_we     (ctl_we),
  .ctl_line   (ctl_line),
  .ctl_wdata  (ctl_wdata),
  .pend_vec   (pend_vec)
);

// File: tb/box_addr_gen_tb.sv
module box_addr_gen_tb;

  localparam int AW = 32;
  localparam int LINES = 16;
  localparam int LW = 4;
  localparam int LOGN = 256;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [AW-1:0]    src_addr = '0, dst_addr = '0;
  logic [31:0]      row_len = '0, row_cnt = '0, row_off = '0;
  logic [LW-1:0]    fc_line = '0;
  logic [LINES-1:0] req_a = '0, req_b = '0;
  logic             ctl_we = 1'b0;
  logic [LW-1:0]    ctl_line = '0;
  logic [18:0]      ctl_wdata = '0;
  logic             beat_valid, done;
  logic [AW-1:0]    rd_addr, wr_addr;

  box_addr_gen #(.AW(AW), .LINES(LINES), .LW(LW)) u_dut (.*);

  always #10 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  int nb = 0, ndone = 0, done_cyc = 0;
  logic [AW-1:0] rd_log [LOGN];
  logic [AW-1:0] wr_log [LOGN];
  int            cyc_log [LOGN];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (beat_valid) begin
      if (nb < LOGN) begin
        rd_log[nb] = rd_addr;
        wr_log[nb] = wr_addr;
        cyc_log[nb] = cyc;
      end
      nb = nb + 1;
    end
    if (done) begin
      ndone = ndone + 1;
      done_cyc = cyc;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    nb = 0;
    ndone = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctl_write(input int line, input logic [18:0] w);
    @(negedge clk);
    ctl_we = 1'b1; ctl_line = LW'(line); ctl_wdata = w;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic pulse_a(input int line);
    @(negedge clk); req_a[line] = 1'b1;
    @(negedge clk); req_a[line] = 1'b0;
  endtask

  task automatic pulse_b(input int line);
    @(negedge clk); req_b[line] = 1'b1;
    @(negedge clk); req_b[line] = 1'b0;
  endtask

  task automatic launch(input logic [31:0] s, input logic [31:0] d, input logic [31:0] l,
                        input logic [31:0] c, input logic [31:0] o, input int line);
    @(negedge clk);
    clr();
    src_addr = s; dst_addr = d; row_len = l; row_cnt = c; row_off = o;
    fc_line = LW'(line); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int lim);
    for (int i = 0; i < lim && ndone == 0; i++) @(negedge clk);
  endtask

  // Compare the logged beats against the expected box pattern.
  task automatic check_box(input string tag, input logic [31:0] s, input logic [31:0] d,
                           input logic [31:0] l, input logic [31:0] c, input logic [31:0] o,
                           input bit contig);
    int ml, mc, bpr, tot, k;
    ml = (l[31:16] < l[15:0]) ? int'(l[31:16]) : int'(l[15:0]);
    mc = (c[31:16] < c[15:0]) ? int'(c[31:16]) : int'(c[15:0]);
    bpr = (ml + 3) / 4;
    tot = bpr * mc;
    chk(nb == tot, {tag, " beat count"}, nb, tot);
    chk(ndone == 1, {tag, " done count"}, ndone, 1);
    if (nb == tot && tot <= LOGN) begin
      k = 0;
      for (int r = 0; r < mc; r++) begin
        for (int b = 0; b < bpr; b++) begin
          logic [31:0] er, ew;
          er = s + r * o[31:16] + 4 * b;
          ew = d + r * o[15:0] + 4 * b;
          chk(rd_log[k] == er, {tag, " rd_addr"}, rd_log[k], er);
          chk(wr_log[k] == ew, {tag, " wr_addr"}, wr_log[k], ew);
          if (contig) chk(cyc_log[k] == cyc_log[0] + k, {tag, " R7 beat gap"}, cyc_log[k], cyc_log[0] + k);
          k++;
        end
      end
      if (tot > 0)
        chk(done_cyc == cyc_log[tot-1] + 1, {tag, " R6 done timing"}, done_cyc, cyc_log[tot-1] + 1);
    end
  endtask

  task automatic t_reset();
    chk(beat_valid == 1'b0, "R1 beat_valid after reset", beat_valid, 0);
    chk(done == 1'b0, "R1 done after reset", done, 0);
  endtask

  task automatic t_basic();
    launch(32'h1000, 32'h8000, 32'h0010_0010, 32'h0003_0003, 32'h0040_0020, 0);
    wait_done(200);
    check_box("R2 R3 basic", 32'h1000, 32'h8000, 32'h0010_0010, 32'h0003_0003, 32'h0040_0020, 1);
  endtask

  task automatic t_halves();
    launch(32'h2000, 32'h3000, 32'h0020_000C, 32'h0005_0002, 32'h0100_0010, 0);
    wait_done(200);
    check_box("R2 R3 smaller half", 32'h2000, 32'h3000, 32'h0020_000C, 32'h0005_0002, 32'h0100_0010, 1);
    launch(32'h40, 32'h80, 32'h0006_0009, 32'h0001_0001, 32'h0, 0);
    wait_done(200);
    check_box("R2 odd length", 32'h40, 32'h80, 32'h0006_0009, 32'h0001_0001, 32'h0, 1);
  endtask

  task automatic t_stride0();
    launch(32'h500, 32'h600, 32'h0008_0008, 32'h0003_0003, 32'h0, 0);
    wait_done(200);
    check_box("R4 zero stride", 32'h500, 32'h600, 32'h0008_0008, 32'h0003_0003, 32'h0, 1);
  endtask

  task automatic t_zero();
    launch(32'h0, 32'h0, 32'h0000_0010, 32'h0002_0002, 32'h0, 0);
    wait_done(50);
    chk(nb == 0, "R5 zero length beats", nb, 0);
    chk(ndone == 1, "R5 zero length done", ndone, 1);
    launch(32'h0, 32'h0, 32'h0010_0010, 32'h0004_0000, 32'h0, 0);
    wait_done(50);
    chk(nb == 0, "R5 zero count beats", nb, 0);
    chk(ndone == 1, "R5 zero count done", ndone, 1);
  endtask

  task automatic t_fc_rows();
    ctl_write(3, 19'd0);
    launch(32'h100, 32'h900, 32'h0010_0010, 32'h0002_0002, 32'h0020_0020, 3);
    idle(10);
    chk(nb == 0, "R8 waits for request", nb, 0);
    pulse_a(5);
    idle(10);
    chk(nb == 0, "R8 other line ignored", nb, 0);
    pulse_a(3);
    idle(10);
    chk(nb == 4, "R8 one row per request", nb, 4);
    chk(ndone == 0, "R8 no done mid command", ndone, 0);
    pulse_a(3);
    wait_done(50);
    check_box("R8 gated rows", 32'h100, 32'h900, 32'h0010_0010, 32'h0002_0002, 32'h0020_0020, 0);
  endtask

  task automatic t_block();
    ctl_write(3, 19'd4);
    launch(32'h0, 32'h4000, 32'h0100_0100, 32'h0001_0001, 32'h0, 3);
    pulse_a(3);
    idle(100);
    chk(nb == 48, "R8 block 192 bytes", nb, 48);
    pulse_a(3);
    wait_done(100);
    chk(nb == 64, "R8 row rest after second request", nb, 64);
    chk(ndone == 1, "R8 done after split row", ndone, 1);
    ctl_write(3, 19'd7);
    launch(32'h0, 32'h4000, 32'h0200_0200, 32'h0001_0001, 32'h0, 3);
    pulse_a(3);
    idle(100);
    chk(nb == 64, "R8 code 7 as 256 bytes", nb, 64);
    pulse_a(3);
    wait_done(100);
    chk(ndone == 1, "R8 code 7 done", ndone, 1);
  endtask

  task automatic t_early();
    ctl_write(2, 19'd5);
    pulse_a(2);
    idle(3);
    launch(32'h700, 32'hA00, 32'h0010_0010, 32'h0001_0001, 32'h0, 2);
    wait_done(50);
    chk(nb == 4, "R9 held request beats", nb, 4);
    chk(ndone == 1, "R9 held request done", ndone, 1);
  endtask

  task automatic t_mux();
    ctl_write(4, 19'h40000);
    launch(32'h0, 32'h100, 32'h0010_0010, 32'h0001_0001, 32'h0, 4);
    pulse_a(4);
    idle(10);
    chk(nb == 0, "R10 primary input deselected", nb, 0);
    pulse_b(4);
    wait_done(50);
    chk(nb == 4, "R10 alternate input releases", nb, 4);
    chk(ndone == 1, "R10 done", ndone, 1);
  endtask

  task automatic t_linerst();
    ctl_write(4, 19'h40002);
    pulse_b(4);
    idle(2);
    ctl_write(4, 19'h60002);
    launch(32'h0, 32'h100, 32'h0020_0020, 32'h0001_0001, 32'h0, 4);
    idle(10);
    chk(nb == 0, "R11 pending dropped", nb, 0);
    pulse_b(4);
    idle(10);
    chk(nb == 0, "R11 alternate deselected", nb, 0);
    pulse_a(4);
    idle(20);
    chk(nb == 4, "R11 code back to 16 bytes", nb, 4);
    pulse_a(4);
    wait_done(50);
    chk(nb == 8 && ndone == 1, "R11 finish", nb, 8);
  endtask

  task automatic t_busy();
    launch(32'h1000, 32'h2000, 32'h0040_0040, 32'h0002_0002, 32'h0100_0100, 0);
    idle(3);
    start = 1'b1; src_addr = 32'hF000; dst_addr = 32'hE000;
    @(negedge clk);
    start = 1'b0;
    src_addr = 32'h1000; dst_addr = 32'h2000;
    wait_done(200);
    idle(20);
    check_box("R12 start ignored while busy", 32'h1000, 32'h2000, 32'h0040_0040, 32'h0002_0002, 32'h0100_0100, 1);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_halves();
    t_stride0();
    t_zero();
    t_fc_rows();
    t_block();
    t_early();
    t_mux();
    t_linerst();
    t_busy();
    finish_run();
  end

endmodule